// File: doc/BRIEF.md
# SPI Target Hold-Pause Front End

This block sits between the pins of an SPI target and the shift logic behind it. It brings chip select, the serial clock, the IO0 data line and the active-low hold line (which doubles as IO3) into a fast system-clock domain through synchronisers. From these it produces three things for the shifter: a one-cycle shift-enable pulse for each qualified serial clock rising edge, a data-output enable that tristates the output during a pause, and a hold-active status bit. Hold entry and hold exit follow the level of the serial clock. When the serial clock is high, entry or exit waits for its next falling edge.

The block also watches the first eight bits of each command, which arrive on IO0 with the most significant bit first. From them it learns the bus width of the command. Quad commands turn the hold line into a data line, so a quad command switches the pause function off. Dual commands still allow pauses. When chip select is released, the command state, the pause state and the bus width are all cleared.

Top module: `spi_hold_front`

## Requirements
- R1: While chip select (`cs_n_i`) is high, edges on `io3_hold_n_i` never make `hold_active_o` high.
- R2: If `io3_hold_n_i` falls while the serial clock is low, the pause begins at once. If it falls while the serial clock is high, `hold_active_o` stays low until the next serial clock falling edge. The latency is three system clocks from the pin change.
- R3: If `io3_hold_n_i` rises while the serial clock is low, the pause ends at once. If it rises while the serial clock is high, `hold_active_o` stays high until the next serial clock falling edge.
- R4: While `hold_active_o` is high, `shift_en_o` and `dout_oe_o` stay low, and toggling the serial clock or IO0 has no effect on command decoding.
- R5: Opcode bits received before a pause are kept. After the pause, decoding continues from the same bit position.
- R6: When chip select rises, even during a pause, `hold_active_o` clears, the opcode bit count resets and `bus_mode_o` returns to 0 (single). The next selection starts a fresh opcode.
- R7: Opcodes 6Bh, EBh, 32h and 34h set `bus_mode_o` to 2 (quad). While in quad mode the hold line never sets `hold_active_o` and shifting continues. Every other opcode that is not dual leaves `bus_mode_o` at 0.
- R8: When `DUAL_EN` is 1, opcodes 3Bh and BBh set `bus_mode_o` to 1 (dual), and pauses are still honoured in dual mode.
- R9: After reset, `hold_active_o`, `shift_en_o` and `dout_oe_o` are 0 and `bus_mode_o` is 0.
- R10: `shift_en_o` is high for exactly one system clock for each serial clock rising edge that occurs while the target is selected and not paused. `dout_oe_o` equals `out_req_i` while the target is selected and not paused, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| io0_i | input | 1 | Data input pin (IO0), carries the opcode |
| io3_hold_n_i | input | 1 | Active-low hold pin, IO3 in quad mode |
| out_req_i | input | 1 | Shifter wants to drive output data |
| shift_en_o | output | 1 | One-cycle qualified shift pulse |
| dout_oe_o | output | 1 | Output driver enable (0 = high impedance) |
| hold_active_o | output | 1 | Pause in effect |
| bus_mode_o | output | 2 | 0 single, 1 dual, 2 quad |

## Verification
The hardest cases to reach are the deferred transitions. These need the hold line to move while the serial clock is held high, so that the pause waits in a pending state until the clock falls. The bench therefore parks the serial clock high across a hold edge, and in one case toggles the clock and IO0 during a pause before releasing it on the high level. A second hard case is releasing chip select in the middle of both a pause and a partly received opcode. The bench checks that the next command decodes from bit zero. A behavioural event model runs beside the design and is compared every system clock.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   localparam int OPC_BITS = 8;

   typedef enum logic [1:0] {
      BUS_X1 = 2'd0,
      BUS_X2 = 2'd1,
      BUS_X4 = 2'd2
   } bus_mode_t;

   typedef enum logic [1:0] {
      HS_RUN        = 2'd0,
      HS_ENTER_WAIT = 2'd1,
      HS_HELD       = 2'd2,
      HS_EXIT_WAIT  = 2'd3
   } hold_state_t;

   function automatic bus_mode_t opcode_width(input logic [OPC_BITS-1:0] op,
                                              input logic dual_ok);
      bus_mode_t m;
      m = BUS_X1;
      case (op)
         8'h6B, 8'hEB, 8'h32, 8'h34: m = BUS_X4;
         8'h3B, 8'hBB: if (dual_ok) m = BUS_X2;
         default: m = BUS_X1;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/shf_sync.sv
module shf_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("shf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else if (i == 0) stg[i] <= d_i;
            else stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/shf_hold_ctl.sv
module shf_hold_ctl
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic hold_en_i,
   input  logic sck_lvl_i,
   input  logic sck_fall_i,
   input  logic hold_fall_i,
   input  logic hold_rise_i,
   output logic held_o
);
   hold_state_t st, st_n;

   always_comb begin
      st_n = st;
      if (!sel_i || !hold_en_i) begin
         st_n = HS_RUN;
      end else begin
         case (st)
            HS_RUN:
               if (hold_fall_i) st_n = sck_lvl_i ? HS_ENTER_WAIT : HS_HELD;
            HS_ENTER_WAIT:
               if (hold_rise_i)     st_n = HS_RUN;
               else if (sck_fall_i) st_n = HS_HELD;
            HS_HELD:
               if (hold_rise_i) st_n = sck_lvl_i ? HS_EXIT_WAIT : HS_RUN;
            HS_EXIT_WAIT:
               if (hold_fall_i)     st_n = HS_HELD;
               else if (sck_fall_i) st_n = HS_RUN;
            default: st_n = HS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= HS_RUN;
      else        st <= st_n;
   end

   assign held_o = (st == HS_HELD) || (st == HS_EXIT_WAIT);

   AST_ENTER_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_o) |-> $past(!sck_lvl_i)); // R2
   AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(held_o) && $past(sel_i) && $past(hold_en_i)) |-> $past(!sck_lvl_i)); // R3
endmodule

// File: rtl/shf_cmd_track.sv
module shf_cmd_track
   import spi_hold_pkg::*;
#(
   parameter bit DUAL_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_i,
   input  logic      shift_en_i,
   input  logic      io0_i,
   output bus_mode_t mode_o
);
   localparam int CNT_W = $clog2(OPC_BITS + 1);

   logic [CNT_W-1:0]    cnt;
   logic [OPC_BITS-1:0] op;
   logic [OPC_BITS-1:0] op_next;
   bus_mode_t           mode_dec;

   assign op_next = {op[OPC_BITS-2:0], io0_i};

   generate
      if (DUAL_EN) begin : g_dual
         assign mode_dec = opcode_width(op_next, 1'b1);
      end else begin : g_nodual
         assign mode_dec = opcode_width(op_next, 1'b0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         op     <= '0;
         mode_o <= BUS_X1;
      end else if (!sel_i) begin
         cnt    <= '0;
         op     <= '0;
         mode_o <= BUS_X1;
      end else if (shift_en_i && (cnt < CNT_W'(OPC_BITS))) begin
         op  <= op_next;
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(OPC_BITS - 1)) mode_o <= mode_dec;
      end
   end

   AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (mode_o == BUS_X1)); // R6
   AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && mode_o != BUS_X1) |=> (mode_o == $past(mode_o))); // R7
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit DUAL_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       sck_i,
   input  logic       io0_i,
   input  logic       io3_hold_n_i,
   input  logic       out_req_i,
   output logic       shift_en_o,
   output logic       dout_oe_o,
   output logic       hold_active_o,
   output logic [1:0] bus_mode_o
);
   localparam int PIN_N   = 4;
   localparam int IX_CS   = 3;
   localparam int IX_SCK  = 2;
   localparam int IX_HOLD = 1;
   localparam int IX_IO0  = 0;
   localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1010;

   logic [PIN_N-1:0] pins_s;
   logic [1:0]       edge_q;
   logic             sel, sck_s, hold_s;
   logic             sck_rise, sck_fall, hold_fall, hold_rise;
   logic             held;
   bus_mode_t        mode;

   shf_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n_i, sck_i, io3_hold_n_i, io0_i}),
      .q_o   (pins_s)
   );

   assign sel    = !pins_s[IX_CS];
   assign sck_s  = pins_s[IX_SCK];
   assign hold_s = pins_s[IX_HOLD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_q <= {PIN_IDLE[IX_SCK], PIN_IDLE[IX_HOLD]};
      else        edge_q <= {sck_s, hold_s};
   end

   assign sck_rise  = !edge_q[1] &&  sck_s;
   assign sck_fall  =  edge_q[1] && !sck_s;
   assign hold_fall =  edge_q[0] && !hold_s;
   assign hold_rise = !edge_q[0] &&  hold_s;

   shf_hold_ctl u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel),
      .hold_en_i   (mode != BUS_X4),
      .sck_lvl_i   (sck_s),
      .sck_fall_i  (sck_fall),
      .hold_fall_i (hold_fall),
      .hold_rise_i (hold_rise),
      .held_o      (held)
   );

   assign shift_en_o = sck_rise && sel && !held;

   shf_cmd_track #(.DUAL_EN(DUAL_EN)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel),
      .shift_en_i (shift_en_o),
      .io0_i      (pins_s[IX_IO0]),
      .mode_o     (mode)
   );

   assign dout_oe_o     = out_req_i && sel && !held;
   assign hold_active_o = held;
   assign bus_mode_o    = mode;

   AST_HOLD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> $past(sel)); // R1
   AST_QUAD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_X4) |-> !hold_active_o); // R7
endmodule

// File: tb/spi_hold_front_test.sv
module spi_hold_front_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, io0 = 1'b0, hold_n = 1'b1, oreq = 1'b1;
   logic shift_en, dout_oe, hold_act;
   logic [1:0] mode;

   int checks = 0, errors = 0, pulses = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_hold_front uut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .io0_i(io0),
      .io3_hold_n_i(hold_n), .out_req_i(oreq), .shift_en_o(shift_en),
      .dout_oe_o(dout_oe), .hold_active_o(hold_act), .bus_mode_o(mode)
   );

   // Behavioural event model: pin samples flow through a three-deep history
   // (two synchroniser stages plus the edge reference), events act on state.
   logic [3:0] h1, h2, h3;  // {cs_n, sck, hold_n, io0}
   int m_st, m_cnt, m_op, m_mode;

   function automatic int width_of(int op);
      if (op == 'h6B || op == 'hEB || op == 'h32 || op == 'h34) return 2;
      if (op == 'h3B || op == 'hBB) return 1;
      return 0;
   endfunction

   task automatic model_reset();
      h1 = 4'b1010; h2 = 4'b1010; h3 = 4'b1010;
      m_st = 0; m_cnt = 0; m_op = 0; m_mode = 0;
   endtask

   function automatic bit m_held();
      return (m_st == 2 || m_st == 3);
   endfunction

   function automatic bit m_shift();
      return !h3[2] && h2[2] && !h2[3] && !m_held();
   endfunction

   task automatic model_step();
      bit sel, sckl, sf, hf, hr, se;
      int nst;
      sel = !h2[3]; sckl = h2[2];
      sf = h3[2] && !h2[2];
      hf = h3[1] && !h2[1];
      hr = !h3[1] && h2[1];
      se = m_shift();
      nst = m_st;
      if (!sel || m_mode == 2) nst = 0;
      else if (m_st == 0 && hf) nst = sckl ? 1 : 2;
      else if (m_st == 1) begin
         if (hr) nst = 0; else if (sf) nst = 2;
      end else if (m_st == 2 && hr) nst = sckl ? 3 : 0;
      else if (m_st == 3) begin
         if (hf) nst = 2; else if (sf) nst = 0;
      end
      if (!sel) begin
         m_cnt = 0; m_op = 0; m_mode = 0;
      end else if (se && m_cnt < 8) begin
         m_op = ((m_op * 2) + int'(h2[0])) % 256;
         m_cnt++;
         if (m_cnt == 8) m_mode = width_of(m_op);
      end
      m_st = nst;
      h3 = h2; h2 = h1; h1 = {cs_n, sck, hold_n, io0};
   endtask

   task automatic cmp(logic [31:0] act, logic [31:0] exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
      #2;
      if (rst_n && !done) begin
         cmp(hold_act, m_held(), "R2/R3 hold_active per-cycle");
         cmp(shift_en, m_shift(), "R10 shift_en per-cycle");
         cmp(dout_oe, oreq && !h2[3] && !m_held(), "R4 dout_oe per-cycle");
         cmp(mode, m_mode, "R7 bus_mode per-cycle");
         if (shift_en) pulses++;
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sck_bit(logic b);
      io0 = b; sck = 1'b0; wait_clk(3);
      sck = 1'b1; wait_clk(3);
      sck = 1'b0;
   endtask

   task automatic send_range(logic [7:0] v, int hi, int lo);
      for (int i = hi; i >= lo; i--) sck_bit(v[i]);
      wait_clk(3);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1200000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int p;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(4);
      // R9 reset state
      cmp(hold_act, 0, "R9 hold_active after reset");
      cmp(shift_en, 0, "R9 shift_en after reset");
      cmp(dout_oe, 0, "R9 dout_oe after reset");
      cmp(mode, 0, "R9 bus_mode after reset");

      // R1: hold edges while deselected
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 0, "R1 hold ignored while deselected");
      hold_n = 1'b1; wait_clk(6);
      p = pulses; sck_bit(1'b1); wait_clk(4);
      cmp(pulses, p, "R10 no shift while deselected");

      // Clock-low entry, pause mid-opcode, clock-high exit, resume (6Bh)
      cs_n = 1'b0; wait_clk(4);
      send_range(8'h6B, 7, 4);
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 1, "R2 clock-low entry immediate");
      p = pulses;
      sck_bit(1'b1); sck_bit(1'b0); wait_clk(3);
      cmp(pulses, p, "R4 serial clock ignored while held");
      cmp(dout_oe, 0, "R4 output tristated while held");
      sck = 1'b1; wait_clk(6);
      hold_n = 1'b1; wait_clk(6);
      cmp(hold_act, 1, "R3 clock-high exit deferred");
      sck = 1'b0; wait_clk(6);
      cmp(hold_act, 0, "R3 exit at serial clock fall");
      send_range(8'h6B, 3, 0);
      cmp(mode, 2, "R5 R7 resumed opcode decodes quad");

      // Quad bypass
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 0, "R7 hold line is data in quad");
      p = pulses; sck_bit(1'b1); wait_clk(4);
      cmp(pulses, p + 1, "R7 shifting continues in quad");
      hold_n = 1'b1; wait_clk(3);
      cs_n = 1'b1; wait_clk(6);
      cmp(mode, 0, "R6 deselect returns to single");

      // Clock-high entry deferred, clock-low exit, dual opcode 3Bh
      cs_n = 1'b0; wait_clk(4);
      p = pulses;
      io0 = 1'b0; sck = 1'b1; wait_clk(6);
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 0, "R2 clock-high entry deferred");
      sck = 1'b0; wait_clk(6);
      cmp(hold_act, 1, "R2 entry at serial clock fall");
      hold_n = 1'b1; wait_clk(6);
      cmp(hold_act, 0, "R3 clock-low exit immediate");
      send_range(8'h3B, 6, 0);
      cmp(pulses, p + 8, "R10 one pulse per serial clock rise");
      cmp(mode, 1, "R8 opcode 3Bh selects dual");
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 1, "R8 hold honoured in dual");
      hold_n = 1'b1; wait_clk(6);
      cs_n = 1'b1; wait_clk(6);

      // Chip select rises during a pause with a partial opcode
      cs_n = 1'b0; wait_clk(4);
      send_range(8'hFF, 7, 5);
      hold_n = 1'b0; wait_clk(6);
      cmp(hold_act, 1, "R6 pause before deselect");
      cs_n = 1'b1; wait_clk(6);
      cmp(hold_act, 0, "R6 deselect clears pause");
      hold_n = 1'b1; wait_clk(6);
      cs_n = 1'b0; wait_clk(4);
      cmp(hold_act, 0, "R6 fresh selection not paused");
      send_range(8'h32, 7, 0);
      cmp(mode, 2, "R6 R7 fresh opcode 32h decodes from bit zero");
      cs_n = 1'b1; wait_clk(6);

      // Non-quad, non-dual opcode stays single
      cs_n = 1'b0; wait_clk(4);
      send_range(8'h03, 7, 0);
      cmp(mode, 0, "R7 other opcode stays single");
      oreq = 1'b0; wait_clk(3);
      cmp(dout_oe, 0, "R10 dout_oe follows request");
      oreq = 1'b1; wait_clk(3);
      cmp(dout_oe, 1, "R10 dout_oe follows request");
      cs_n = 1'b1; wait_clk(6);

      finish_run();
   end
endmodule